// File: doc/BRIEF.md
# SECDED Memory Controller with Corrected-Word Cache

This controller sits between a single requester and a synchronous SRAM that stores each 64-bit data word together with eight check bits. The check bits form an extended Hamming code. Writes are encoded on the way into the SRAM. Reads are decoded, corrected where the code permits, and returned to the requester. The requester uses a valid/ready request port and a one-cycle response pulse. The SRAM side has an enable, a write strobe, an address and 72-bit data. Read data arrives one clock after the enable.

When a read finds a correctable error, the controller records the address and the repaired word in a one-entry cache. It writes the repaired code word back to the SRAM and then performs the lookup again. The second lookup hits the cache, so a cell that is permanently stuck cannot hold the controller in a loop of repair attempts. While an address stays cached, its reads never reach the SRAM and raise no further error reports. An uncorrectable error leaves the cache and the SRAM untouched and returns an error response.

Sticky status flags and captured addresses report both error kinds until software clears them with a dedicated input.

Top module: `ecc_hec_ctrl`

## Requirements
- R1: A written word is stored as 72 bits: data in bits 63:0, seven Hamming bits in 70:64 and overall parity in bit 71. A read of an undamaged word returns the written data with `rsp_err` low after exactly one SRAM read and no SRAM write.
- R2: If any single bit of the 72 read from the SRAM is inverted, the response carries the original data with `rsp_err` low, and `sbe_flag` is set. This holds for data, Hamming and parity bits alike.
- R3: Each correctable error is followed by exactly one SRAM write of the repaired code word to the same address before the response. A request never causes more than one such write, even when the fault is permanent.
- R4: After a correctable error, the address and repaired data are cached. A later read of that address returns the cached data without any SRAM read and does not set `sbe_flag`.
- R5: The cache holds one entry. A correctable error at another address replaces it, after which the first address is read from the SRAM again and its fault is reported again.
- R6: If two bits of the stored word are inverted, the response has `rsp_err` high and `rsp_rdata` zero. `dbe_flag` is set, and neither an SRAM write nor a cache fill takes place.
- R7: A write to the cached address writes the SRAM and replaces the cached data, so a later hit returns the new data.
- R8: Reset invalidates the cache and clears both flags and both captured addresses.
- R9: `sbe_flag` and `dbe_flag` stay set until `stat_clr` is high at a clock edge. A detection in the same cycle as `stat_clr` leaves the flag set.
- R10: `sbe_addr`/`dbe_addr` load the request address only when their flag is clear or being cleared in that cycle. A further error while the flag stays set leaves the captured address unchanged.
- R11: `req_ready` is high only while no request is in progress. Each request produces exactly one single-cycle `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data (zero on writes and on uncorrectable reads) |
| rsp_err | output | 1 | Uncorrectable read |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write strobe |
| mem_addr | output | ADDR_W | SRAM address |
| mem_wdata | output | CODE_W | Encoded word to SRAM |
| mem_rdata | input | CODE_W | Encoded word from SRAM, one cycle after a read enable |
| stat_clr | input | 1 | Clears both status flags |
| sbe_flag | output | 1 | Sticky correctable-error flag |
| sbe_addr | output | ADDR_W | Address captured with the correctable-error flag |
| dbe_flag | output | 1 | Sticky uncorrectable-error flag |
| dbe_addr | output | ADDR_W | Address captured with the uncorrectable-error flag |

## Verification
A software clear of the status flags and a fresh error detection can land on the same clock edge. The clear then competes with the set, and the address capture must decide whether the flag counts as new. The bench holds `stat_clr` high for the whole of a read whose stored word has two inverted bits, so the clear is still asserted on the edge that registers the detection. It releases the clear on the cycle the response appears. The result is judged by `dbe_flag` being high with `dbe_addr` equal to that read's address, and by the flag still being high one cycle after the clear is released.

// File: rtl/ecc_hec_pkg.sv
package ecc_hec_pkg;

   localparam int MAX_DW = 256;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_CHK,
      ST_SCRUB,
      ST_WR
   } st_e;

   // number of Hamming bits needed so that every code position has a syndrome
   function automatic int calc_ham_w(input int dw);
      int p;
      p = 1;
      while ((1 << p) < dw + p + 1) p++;
      return p;
   endfunction

   // code position (1-based) of data bit idx; powers of two are Hamming bits
   function automatic int code_pos(input int idx);
      int pos;
      int cnt;
      pos = 2;
      cnt = -1;
      while (cnt < idx) begin
         pos++;
         if ((pos & (pos - 1)) != 0) cnt++;
      end
      return pos;
   endfunction

   // data bits covered by Hamming bit j
   function automatic logic [MAX_DW-1:0] cover_mask(input int dw, input int j);
      logic [MAX_DW-1:0] m;
      m = '0;
      for (int i = 0; i < dw; i++) begin
         if (((code_pos(i) >> j) & 1) == 1) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/ecc_hec_enc.sv
module ecc_hec_enc #(
   parameter int DATA_W = 64,
   parameter int HAM_W  = ecc_hec_pkg::calc_ham_w(DATA_W)
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [HAM_W-1:0]  ham_o
);
   import ecc_hec_pkg::*;

   for (genvar j = 0; j < HAM_W; j++) begin : g_ham
      localparam logic [MAX_DW-1:0] FULL = cover_mask(DATA_W, j);
      localparam logic [DATA_W-1:0] MASK = FULL[DATA_W-1:0];
      assign ham_o[j] = ^(data_i & MASK);
   end

endmodule

// File: rtl/ecc_hec_dec.sv
module ecc_hec_dec #(
   parameter int DATA_W = 64,
   parameter int HAM_W  = ecc_hec_pkg::calc_ham_w(DATA_W),
   parameter int CODE_W = DATA_W + HAM_W + 1
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [DATA_W-1:0] data_o,
   output logic              sbe_o,
   output logic              dbe_o
);
   import ecc_hec_pkg::*;

   localparam logic [HAM_W-1:0] TOP_POS = HAM_W'(DATA_W + HAM_W);

   logic [HAM_W-1:0]  ham_calc;
   logic [HAM_W-1:0]  syn;
   logic              par_err;
   logic [DATA_W-1:0] flip;

   ecc_hec_enc #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc (
      .data_i (code_i[DATA_W-1:0]),
      .ham_o  (ham_calc)
   );

   assign syn     = ham_calc ^ code_i[DATA_W +: HAM_W];
   assign par_err = ^code_i;

   for (genvar i = 0; i < DATA_W; i++) begin : g_fix
      localparam logic [HAM_W-1:0] POS = HAM_W'(code_pos(i));
      assign flip[i] = par_err && (syn == POS);
   end

   // syndrome zero with parity error: the overall parity bit itself
   assign sbe_o  = par_err && (syn <= TOP_POS);
   assign dbe_o  = (!par_err && (syn != '0)) || (par_err && (syn > TOP_POS));
   assign data_o = code_i[DATA_W-1:0] ^ flip;

endmodule

// File: rtl/ecc_hec_cache.sv
module ecc_hec_cache #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 64,
   parameter bit HEC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              fill_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              hit_o,
   output logic [DATA_W-1:0] data_o
);

   if (HEC_EN) begin : g_entry
      logic              valid_q;
      logic [ADDR_W-1:0] tag_q;
      logic [DATA_W-1:0] data_q;

      assign hit_o  = valid_q && (tag_q == addr_i);
      assign data_o = data_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            data_q  <= '0;
         end else if (fill_i) begin
            valid_q <= 1'b1;
            tag_q   <= addr_i;
            data_q  <= data_i;
         end else if (wr_i && hit_o) begin
            data_q  <= data_i;
         end
      end

      assert_fill_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
         fill_i |=> (valid_q && tag_q == $past(addr_i) && data_q == $past(data_i)));

      assert_write_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_i && hit_o && !fill_i) |=> (valid_q && data_q == $past(data_i)));

      assert_replace_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (fill_i && valid_q && tag_q != addr_i) |=> (tag_q != $past(tag_q)));
   end else begin : g_none
      assign hit_o  = 1'b0;
      assign data_o = '0;
   end

endmodule

// File: rtl/ecc_hec_ctrl.sv
module ecc_hec_ctrl #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 64,
   parameter bit HEC_EN = 1'b1,
   parameter int HAM_W  = ecc_hec_pkg::calc_ham_w(DATA_W),
   parameter int CODE_W = DATA_W + HAM_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [CODE_W-1:0] mem_wdata,
   input  logic [CODE_W-1:0] mem_rdata,
   input  logic              stat_clr,
   output logic              sbe_flag,
   output logic [ADDR_W-1:0] sbe_addr,
   output logic              dbe_flag,
   output logic [ADDR_W-1:0] dbe_addr
);
   import ecc_hec_pkg::*;

   // elaboration checks on the parameter set
   if (HAM_W != calc_ham_w(DATA_W)) begin : g_bad_ham
      $error("HAM_W does not match DATA_W");
   end
   if (CODE_W != DATA_W + HAM_W + 1) begin : g_bad_code
      $error("CODE_W must be DATA_W + HAM_W + 1");
   end
   if (DATA_W < 8 || DATA_W > MAX_DW) begin : g_bad_dw
      $error("DATA_W out of range");
   end
   if (ADDR_W < 1) begin : g_bad_aw
      $error("ADDR_W must be positive");
   end

   st_e               state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] fix_q;
   logic              retry_q;
   logic              rsp_valid_q;
   logic [DATA_W-1:0] rsp_data_q;
   logic              rsp_err_q;
   logic              sbe_flag_q, dbe_flag_q;
   logic [ADDR_W-1:0] sbe_addr_q, dbe_addr_q;

   logic [DATA_W-1:0] enc_src;
   logic [HAM_W-1:0]  enc_ham;
   logic [DATA_W-1:0] dec_data;
   logic              dec_sbe, dec_dbe;
   logic              in_chk, sbe_hit, dbe_hit;
   logic              c_hit;
   logic [DATA_W-1:0] c_data;
   logic              in_wr;

   // ---------------- encode path ----------------
   assign enc_src = (state_q == ST_SCRUB) ? fix_q : wdata_q;

   ecc_hec_enc #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc (
      .data_i (enc_src),
      .ham_o  (enc_ham)
   );

   assign mem_wdata = {^{enc_ham, enc_src}, enc_ham, enc_src};
   assign mem_addr  = addr_q;
   assign in_wr     = (state_q == ST_WR);
   assign mem_we    = (state_q == ST_SCRUB) || in_wr;
   assign mem_en    = ((state_q == ST_LOOK) && !c_hit) || mem_we;

   // ---------------- decode path ----------------
   ecc_hec_dec #(.DATA_W(DATA_W), .HAM_W(HAM_W), .CODE_W(CODE_W)) u_dec (
      .code_i (mem_rdata),
      .data_o (dec_data),
      .sbe_o  (dec_sbe),
      .dbe_o  (dec_dbe)
   );

   assign in_chk  = (state_q == ST_CHK);
   assign sbe_hit = in_chk && dec_sbe;
   assign dbe_hit = in_chk && dec_dbe;

   // ---------------- corrected-word cache ----------------
   ecc_hec_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HEC_EN(HEC_EN)) u_cache (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr_i (addr_q),
      .fill_i (sbe_hit && !retry_q),
      .wr_i   (in_wr),
      .data_i (in_wr ? wdata_q : dec_data),
      .hit_o  (c_hit),
      .data_o (c_data)
   );

   // ---------------- request sequencer ----------------
   assign req_ready = (state_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         wdata_q     <= '0;
         fix_q       <= '0;
         retry_q     <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
         rsp_err_q   <= 1'b0;
      end else begin
         rsp_valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
                  retry_q <= 1'b0;
                  state_q <= req_we ? ST_WR : ST_LOOK;
               end
            end
            ST_LOOK: begin
               if (c_hit) begin
                  rsp_valid_q <= 1'b1;
                  rsp_data_q  <= c_data;
                  rsp_err_q   <= 1'b0;
                  state_q     <= ST_IDLE;
               end else begin
                  state_q     <= ST_CHK;
               end
            end
            ST_CHK: begin
               if (dec_dbe) begin
                  rsp_valid_q <= 1'b1;
                  rsp_data_q  <= '0;
                  rsp_err_q   <= 1'b1;
                  state_q     <= ST_IDLE;
               end else if (dec_sbe && !retry_q) begin
                  fix_q       <= dec_data;
                  state_q     <= ST_SCRUB;
               end else begin
                  // clean word, or second failure after one repair: deliver it
                  rsp_valid_q <= 1'b1;
                  rsp_data_q  <= dec_data;
                  rsp_err_q   <= 1'b0;
                  state_q     <= ST_IDLE;
               end
            end
            ST_SCRUB: begin
               retry_q <= 1'b1;
               state_q <= ST_LOOK;
            end
            ST_WR: begin
               rsp_valid_q <= 1'b1;
               rsp_data_q  <= '0;
               rsp_err_q   <= 1'b0;
               state_q     <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_rdata = rsp_data_q;
   assign rsp_err   = rsp_err_q;

   // ---------------- sticky status ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sbe_flag_q <= 1'b0;
         dbe_flag_q <= 1'b0;
         sbe_addr_q <= '0;
         dbe_addr_q <= '0;
      end else begin
         if (sbe_hit)       sbe_flag_q <= 1'b1;
         else if (stat_clr) sbe_flag_q <= 1'b0;
         if (dbe_hit)       dbe_flag_q <= 1'b1;
         else if (stat_clr) dbe_flag_q <= 1'b0;
         if (sbe_hit && (!sbe_flag_q || stat_clr)) sbe_addr_q <= addr_q;
         if (dbe_hit && (!dbe_flag_q || stat_clr)) dbe_addr_q <= addr_q;
      end
   end

   assign sbe_flag = sbe_flag_q;
   assign dbe_flag = dbe_flag_q;
   assign sbe_addr = sbe_addr_q;
   assign dbe_addr = dbe_addr_q;

   // ---------------- assertions ----------------
   assert_chk_follows_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CHK) |-> $past(mem_en && !mem_we));

   assert_scrub_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SCRUB) |-> !retry_q);

   assert_dbe_response_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dbe_hit |=> (rsp_valid && rsp_err && dbe_flag));

   assert_sbe_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sbe_flag && !stat_clr) |=> sbe_flag);

   assert_dbe_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dbe_flag && !stat_clr) |=> dbe_flag);

   assert_sbe_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sbe_flag && !stat_clr) |=> $stable(sbe_addr));

   assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid) |=> !req_ready);

endmodule

// File: tb/ecc_hec_ctrl_tb_top.sv
module ecc_hec_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int DW = 64;
   localparam int CW = 72;
   localparam logic [7:0] NONE = 8'hFF;

   typedef struct packed {
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic [7:0]    f0;
      logic [7:0]    f1;
   } vec_t;

   // address, data, first flipped bit, second flipped bit (FF = none)
   localparam vec_t VEC [8] = '{
      '{6'd1, 64'h0123_4567_89AB_CDEF, NONE,  NONE},
      '{6'd2, 64'hFFFF_0000_FFFF_0000, 8'd0,  NONE},
      '{6'd3, 64'hDEAD_BEEF_CAFE_F00D, 8'd63, NONE},
      '{6'd4, 64'h5555_AAAA_5555_AAAA, 8'd64, NONE},
      '{6'd5, 64'h0000_0000_0000_0000, 8'd70, NONE},
      '{6'd6, 64'hFFFF_FFFF_FFFF_FFFF, 8'd71, NONE},
      '{6'd7, 64'h1357_9BDF_2468_ACE0, 8'd3,  8'd40},
      '{6'd8, 64'h8000_0000_0000_0001, 8'd64, 8'd71}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_err;
   logic          mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [CW-1:0] mem_wdata;
   logic [CW-1:0] mem_rdata = '0;
   logic          stat_clr = 1'b0;
   logic          sbe_flag, dbe_flag;
   logic [AW-1:0] sbe_addr, dbe_addr;

   ecc_hec_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .stat_clr(stat_clr),
      .sbe_flag(sbe_flag), .sbe_addr(sbe_addr),
      .dbe_flag(dbe_flag), .dbe_addr(dbe_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- SRAM model with fault injection ----------------
   logic [CW-1:0] mem [64];
   int            rd_cnt = 0;
   int            wr_cnt = 0;
   logic          inj_en = 1'b0;
   logic [AW-1:0] inj_addr = '0;
   logic [CW-1:0] inj_mask = '0;
   logic [AW-1:0] stk_a0 = '0, stk_a1 = '0;
   logic [CW-1:0] stk_m0 = '0, stk_m1 = '0;

   function automatic logic [CW-1:0] stuck(input logic [AW-1:0] a);
      return ((a == stk_a0) ? stk_m0 : '0) | ((a == stk_a1) ? stk_m1 : '0);
   endfunction

   always @(posedge clk) begin
      if (inj_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
      if (mem_en) begin
         if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rdata <= mem[mem_addr] ^ stuck(mem_addr);
            rd_cnt <= rd_cnt + 1;
         end
      end
   end

   // ---------------- bookkeeping ----------------
   int n_chk = 0;
   int n_bad = 0;
   logic [DW-1:0] got_data;
   logic          got_err;
   logic          busy_ready;
   int            nrd, nwr;

   task automatic ceq(input string tag, input string what,
                      input logic [CW-1:0] act, input logic [CW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic xfer(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int rd0, wr0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      rd0 = rd_cnt; wr0 = wr_cnt;
      @(negedge clk);
      req_valid = 1'b0;
      busy_ready = req_ready;
      while (!rsp_valid) @(negedge clk);
      got_data = rsp_rdata; got_err = rsp_err;
      nrd = rd_cnt - rd0; nwr = wr_cnt - wr0;
   endtask

   task automatic inject(input logic [AW-1:0] a, input logic [CW-1:0] m);
      @(negedge clk);
      inj_addr = a; inj_mask = m; inj_en = 1'b1;
      @(negedge clk);
      inj_en = 1'b0;
   endtask

   task automatic clear_pulse();
      @(negedge clk); stat_clr = 1'b1;
      @(negedge clk); stat_clr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog: actual no response expected response");
      summary();
      $finish;
   end

   initial begin
      logic [CW-1:0] clean;
      logic [CW-1:0] m;
      logic          dbl, sgl;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      ceq("R8", "sbe_flag after reset", CW'(sbe_flag), 72'd0);
      ceq("R8", "dbe_flag after reset", CW'(dbe_flag), 72'd0);
      ceq("R11", "req_ready idle", CW'(req_ready), 72'd1);
      ceq("R11", "rsp_valid idle", CW'(rsp_valid), 72'd0);

      // ---------------- vector table: R1 R2 R3 R6 ----------------
      for (int k = 0; k < 8; k++) begin
         clear_pulse();
         xfer(1'b1, VEC[k].addr, VEC[k].data);
         clean = mem[VEC[k].addr];
         sgl = (VEC[k].f0 != NONE) && (VEC[k].f1 == NONE);
         dbl = (VEC[k].f1 != NONE);
         m = '0;
         if (VEC[k].f0 != NONE) m[VEC[k].f0] = 1'b1;
         if (VEC[k].f1 != NONE) m[VEC[k].f1] = 1'b1;
         if (m != '0) inject(VEC[k].addr, m);
         xfer(1'b0, VEC[k].addr, '0);
         if (dbl) begin
            ceq("R6", "double: rsp_err", CW'(got_err), 72'd1);
            ceq("R6", "double: rdata zero", CW'(got_data), 72'd0);
            ceq("R6", "double: no write", CW'(nwr), 72'd0);
            ceq("R6", "double: dbe_flag", CW'(dbe_flag), 72'd1);
            ceq("R6", "double: dbe_addr", CW'(dbe_addr), CW'(VEC[k].addr));
            ceq("R6", "double: sbe_flag", CW'(sbe_flag), 72'd0);
         end else begin
            ceq(sgl ? "R2" : "R1", "read data", CW'(got_data), CW'(VEC[k].data));
            ceq(sgl ? "R2" : "R1", "rsp_err", CW'(got_err), 72'd0);
            ceq(sgl ? "R2" : "R1", "sbe_flag", CW'(sbe_flag), CW'(sgl));
            ceq("R1", "one SRAM read", CW'(nrd), 72'd1);
            ceq("R3", "write-back count", CW'(nwr), CW'(sgl));
            ceq("R3", "stored word repaired", mem[VEC[k].addr], clean);
            if (sgl) ceq("R2", "sbe_addr", CW'(sbe_addr), CW'(VEC[k].addr));
         end
      end

      // ---------------- permanent fault: R3 R4 ----------------
      clear_pulse();
      xfer(1'b1, 6'd10, 64'hA5A5_0F0F_1234_5678);
      ceq("R11", "busy: req_ready low", CW'(busy_ready), 72'd0);
      @(negedge clk);
      ceq("R11", "rsp_valid single cycle", CW'(rsp_valid), 72'd0);
      stk_a0 = 6'd10; stk_m0 = 72'd1 << 5;
      xfer(1'b0, 6'd10, '0);
      ceq("R3", "hard fault: data", CW'(got_data), 72'hA5A5_0F0F_1234_5678);
      ceq("R3", "hard fault: one write-back", CW'(nwr), 72'd1);
      ceq("R3", "hard fault: one SRAM read", CW'(nrd), 72'd1);
      ceq("R2", "hard fault: sbe_addr", CW'(sbe_addr), 72'd10);
      clear_pulse();
      xfer(1'b0, 6'd10, '0);
      ceq("R4", "hit: data", CW'(got_data), 72'hA5A5_0F0F_1234_5678);
      ceq("R4", "hit: no SRAM read", CW'(nrd), 72'd0);
      ceq("R4", "hit: sbe_flag stays low", CW'(sbe_flag), 72'd0);

      // ---------------- write to cached address: R7 ----------------
      xfer(1'b1, 6'd10, 64'h1111_2222_3333_4444);
      ceq("R7", "write reaches SRAM", CW'(nwr), 72'd1);
      xfer(1'b0, 6'd10, '0);
      ceq("R7", "hit returns new data", CW'(got_data), 72'h1111_2222_3333_4444);
      ceq("R7", "hit: no SRAM read", CW'(nrd), 72'd0);

      // ---------------- replacement: R5 ----------------
      xfer(1'b1, 6'd20, 64'h7777_8888_9999_AAAA);
      stk_a1 = 6'd20; stk_m1 = 72'd1 << 66;
      xfer(1'b0, 6'd20, '0);
      ceq("R5", "second address corrected", CW'(got_data), 72'h7777_8888_9999_AAAA);
      ceq("R5", "second address captured", CW'(sbe_addr), 72'd20);
      clear_pulse();
      xfer(1'b0, 6'd10, '0);
      ceq("R5", "first address reads SRAM", CW'(nrd), 72'd1);
      ceq("R5", "first address reported again", CW'(sbe_flag), 72'd1);
      ceq("R5", "first address data", CW'(got_data), 72'h1111_2222_3333_4444);
      ceq("R5", "first address captured", CW'(sbe_addr), 72'd10);

      // ---------------- sticky flag, address hold: R9 R10 ----------------
      xfer(1'b0, 6'd20, '0);
      ceq("R10", "address kept while flag set", CW'(sbe_addr), 72'd10);
      ceq("R9", "flag still set", CW'(sbe_flag), 72'd1);

      // ---------------- clear colliding with detection: R9 R10 ----------------
      xfer(1'b1, 6'd30, 64'h0F1E_2D3C_4B5A_6978);
      inject(6'd30, (72'd1 << 10) | (72'd1 << 20));
      @(negedge clk); stat_clr = 1'b1;
      xfer(1'b0, 6'd30, '0);
      stat_clr = 1'b0;
      ceq("R9", "set wins over clear", CW'(dbe_flag), 72'd1);
      ceq("R10", "capture on clear cycle", CW'(dbe_addr), 72'd30);
      ceq("R6", "collision: rsp_err", CW'(got_err), 72'd1);
      @(negedge clk);
      ceq("R9", "flag holds after clear drop", CW'(dbe_flag), 72'd1);
      ceq("R9", "held clear removed sbe_flag", CW'(sbe_flag), 72'd0);

      // ---------------- reset invalidates cache: R8 ----------------
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      ceq("R8", "dbe_flag cleared", CW'(dbe_flag), 72'd0);
      ceq("R8", "dbe_addr cleared", CW'(dbe_addr), 72'd0);
      xfer(1'b0, 6'd20, '0);
      ceq("R8", "cache invalid: SRAM read", CW'(nrd), 72'd1);
      ceq("R8", "cache invalid: error seen", CW'(sbe_flag), 72'd1);
      ceq("R8", "cache invalid: data", CW'(got_data), 72'h7777_8888_9999_AAAA);

      summary();
      $finish;
   end

endmodule